// File: doc/BRIEF.md
# Serial Register Host Sequencer

This block is the host side of a two-wire, half-duplex register port. It produces the serial clock and drives or releases the shared data line so that a command interface can read and write 8-bit registers at 7-bit addresses in a slave device. A transaction is sixteen clock periods. A direction bit comes first, then the address and then the data byte. On a write the host drives all sixteen bits. On a read the host drives the first eight bits and then lets go of the line so that the slave can return the data.

Every timing rule is enforced by counting system clocks, and all such counts are parameters. They cover the width of each clock phase, a long pause with the clock held high in the middle of a read, and the gap before the next command. The length of that gap depends on whether the command before it was a read or a write. Out of reset the block can optionally wait out the slave's transaction watchdog. It then reads the status register and reports whether the identity bits match, which shows whether the port is in step. A dedicated request flag issues the soft-reset command.

Top module: `sio_host_seq`

## Requirements
- R1: After reset, `sck` is high, `sdio_oe` is low and `ready` is low until the power-up check has finished. The first falling `sck` edge comes at least PWRUP_CYC system clocks after reset is released.
- R2: A transaction is 16 `sck` periods. Each low phase lasts exactly HALF_CYC system clocks and each high phase lasts at least HALF_CYC clocks.
- R3: `sdio_out` changes only in a clock where `sck` falls. The bits go out in this order: bit 1 is 1 for a write and 0 for a read, bits 2 to 8 are the address MSB first, and bits 9 to 16 are the data MSB first.
- R4: On a read, `sdio_oe` drops after the eighth rising `sck` edge and stays low through the data bits. `sck` stays high for at least TURN_CYC clocks between the eighth rising edge and the ninth falling edge.
- R5: Read data is sampled from `sdio_in` on rising edges 9 to 16, MSB first. It appears on `rd_data` when `done` pulses.
- R6: After a write, at least WR_GAP_CYC clocks pass between its last rising `sck` and the first falling `sck` of the next transaction.
- R7: After a read, at least RD_GAP_CYC clocks pass between its last rising `sck` and the first falling `sck` of the next transaction.
- R8: A request is taken only in a clock where `ready` and `req_valid` are both high. `ready` is then low until the transaction ends, and `done` is a single-clock pulse.
- R9: With `req_reset` set, the request sends a write of 0x80 to address 0x00, whatever `req_write`, `req_addr` and `req_wdata` hold.
- R10: The power-up check reads address 0x01 and sets `sync_done`. It sets `sync_ok` to 1 exactly when bits 7:5 of the returned byte are 000. It does not pulse `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reset | input | 1 | Send the soft-reset write instead of the given command |
| req_addr | input | 7 | Register address |
| req_wdata | input | 8 | Write data |
| ready | output | 1 | Block idle and all gaps satisfied |
| done | output | 1 | One-clock pulse at the end of a requested transaction |
| rd_data | output | 8 | Last byte read |
| sync_done | output | 1 | Power-up check finished |
| sync_ok | output | 1 | Power-up identity bits matched |
| sck | output | 1 | Serial clock, idles high |
| sdio_out | output | 1 | Host data toward the slave |
| sdio_oe | output | 1 | Host drives the data line when high |
| sdio_in | input | 1 | Data line as seen by the host |

## Verification
Most internal faults appear on the bus within one transaction. If the bit counter slips, the frame length or the bit placement is wrong by the sixteenth rising edge. A phase counter that is wrong gives a low phase of the wrong width at the very next rising edge. A gap timer that is loaded with the wrong value lets the next falling edge arrive too early. A wrong direction flag keeps `sdio_oe` high while the slave drives, so a collision shows by the ninth falling edge. A fault in power-up sequencing shows as an early first edge or as a wrong `sync_ok` about 16 bit times after the wait ends.

// File: rtl/sio_host_pkg.sv
// Shared types and protocol constants for the serial register host.
package sio_host_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PWAIT = 3'd1,
        ST_LOW   = 3'd2,
        ST_HIGH  = 3'd3,
        ST_TURN  = 3'd4
    } seq_state_t;

    localparam logic [6:0] SOFT_RST_ADDR = 7'h00;
    localparam logic [7:0] SOFT_RST_DATA = 8'h80;
    localparam logic [6:0] SYNC_ADDR     = 7'h01;
    localparam int         FRAME_BITS    = 16;
    localparam int         HALF_BITS     = 8;

endpackage

// File: rtl/sio_down_timer.sv
// Down counter with load. It holds at zero and flags zero.
// Assumes: a load has priority over counting, and RESET_VAL fits in W bits.
module sio_down_timer #(
    parameter int W         = 8,
    parameter int RESET_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Load a value or step toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= W'(RESET_VAL);
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    AST_TMR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && zero) |=> zero); // R2

endmodule

// File: rtl/sio_bit_shifter.sv
// Transmit shifter and receive capture for the serial frame.
// Assumes: load takes the place of the first shift-out, step_out comes on the
// later falling edges, and step_in comes on the rising edges that carry read data.
module sio_bit_shifter #(
    parameter int WORD_W = 16,
    parameter int RX_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              step_out,
    input  logic              step_in,
    input  logic              sdi,
    output logic              sdo,
    output logic [RX_W-1:0]   rx_byte
);
    logic [WORD_W-1:0] tx_q;
    logic              sdo_q;
    logic [RX_W-1:0]   rx_q;

    // Present the next bit on each falling edge, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q  <= '0;
            sdo_q <= 1'b0;
        end else if (load) begin
            sdo_q <= load_word[WORD_W-1];
            tx_q  <= {load_word[WORD_W-2:0], 1'b0};
        end else if (step_out) begin
            sdo_q <= tx_q[WORD_W-1];
            tx_q  <= {tx_q[WORD_W-2:0], 1'b0};
        end
    end

    // Capture returned data on the rising edges, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_q <= '0;
        else if (step_in) rx_q <= {rx_q[RX_W-2:0], sdi};
    end

    assign sdo     = sdo_q;
    assign rx_byte = rx_q;

    AST_SDO_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step_out) |=> $stable(sdo)); // R3

endmodule

// File: rtl/sio_host_seq.sv
// Host sequencer for a two-wire half-duplex register port.
// It runs 16-bit read and write frames and counts every timing gap in
// system clocks. An optional power-up wait and sync read runs first.
// Assumes: the bus pad combines sdio_out/sdio_oe/sdio_in, and the
// slave changes read data on falling sck.
module sio_host_seq
    import sio_host_pkg::*;
#(
    parameter int HALF_CYC   = 63,
    parameter int TURN_CYC   = 25000,
    parameter int WR_GAP_CYC = 25000,
    parameter int RD_GAP_CYC = 63,
    parameter int PWRUP_CYC  = 22600000,
    parameter bit PWRUP_EN   = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       req_reset,
    input  logic [6:0] req_addr,
    input  logic [7:0] req_wdata,
    output logic       ready,
    output logic       done,
    output logic [7:0] rd_data,
    output logic       sync_done,
    output logic       sync_ok,
    output logic       sck,
    output logic       sdio_out,
    output logic       sdio_oe,
    input  logic       sdio_in
);
    localparam int PH_MAX  = (HALF_CYC > TURN_CYC) ? HALF_CYC : TURN_CYC;
    localparam int PH_W    = $clog2(PH_MAX + 1);
    localparam int GAP_A   = (WR_GAP_CYC > RD_GAP_CYC) ? WR_GAP_CYC : RD_GAP_CYC;
    localparam int GAP_MAX = (GAP_A > PWRUP_CYC) ? GAP_A : PWRUP_CYC;
    localparam int GAP_W   = $clog2(GAP_MAX + 1);
    localparam int GAP_RST = PWRUP_EN ? PWRUP_CYC : 0;
    localparam int CNT_W   = $clog2(FRAME_BITS + 1);
    localparam seq_state_t ST_RST = PWRUP_EN ? ST_PWAIT : ST_IDLE;

    seq_state_t        state_q, state_d;
    logic [CNT_W-1:0]  bit_q;
    logic              wr_q, own_q, sck_q, oe_q, done_q, sdone_q, sok_q;
    logic [7:0]        rd_q, rx_byte;
    logic              ph_load, ph_zero, gap_load, gap_zero;
    logic [PH_W-1:0]   ph_val;
    logic [GAP_W-1:0]  gap_val;
    logic              launch, step_out, rise, enter_turn, finish;
    logic [15:0]       launch_word;

    sio_down_timer #(.W(PH_W), .RESET_VAL(0)) i_phase_tmr (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero));

    sio_down_timer #(.W(GAP_W), .RESET_VAL(GAP_RST)) i_gap_tmr (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .zero(gap_zero));

    sio_bit_shifter #(.WORD_W(FRAME_BITS), .RX_W(8)) i_shifter (
        .clk(clk), .rst_n(rst_n), .load(launch), .load_word(launch_word),
        .step_out(step_out), .step_in(rise && !wr_q && (bit_q >= CNT_W'(HALF_BITS))),
        .sdi(sdio_in), .sdo(sdio_out), .rx_byte(rx_byte));

    // Pick the frame to send: sync read, soft reset, or the caller's command.
    always_comb begin
        if (state_q == ST_PWAIT)  launch_word = {1'b0, SYNC_ADDR, 8'h00};
        else if (req_reset)       launch_word = {1'b1, SOFT_RST_ADDR, SOFT_RST_DATA};
        else                      launch_word = {req_write, req_addr, req_wdata};
    end

    // Next state and timer loads for the phase and gap counters.
    always_comb begin
        state_d    = state_q;
        ph_load    = 1'b0;
        ph_val     = PH_W'(HALF_CYC - 1);
        gap_load   = 1'b0;
        gap_val    = wr_q ? GAP_W'(WR_GAP_CYC) : GAP_W'(RD_GAP_CYC);
        launch     = 1'b0;
        step_out   = 1'b0;
        rise       = 1'b0;
        enter_turn = 1'b0;
        finish     = 1'b0;
        case (state_q)
            ST_IDLE, ST_PWAIT: begin
                if (gap_zero && (req_valid || state_q == ST_PWAIT)) begin
                    state_d = ST_LOW;
                    ph_load = 1'b1;
                    launch  = 1'b1;
                end
            end
            ST_LOW: begin
                if (ph_zero) begin
                    state_d  = ST_HIGH;
                    ph_load  = 1'b1;
                    rise     = 1'b1;
                    gap_load = (bit_q == CNT_W'(FRAME_BITS - 1));
                end
            end
            ST_HIGH: begin
                if (ph_zero) begin
                    if (bit_q == CNT_W'(FRAME_BITS)) begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                    end else if (bit_q == CNT_W'(HALF_BITS) && !wr_q) begin
                        state_d    = ST_TURN;
                        ph_load    = 1'b1;
                        ph_val     = PH_W'(TURN_CYC - 1);
                        enter_turn = 1'b1;
                    end else begin
                        state_d  = ST_LOW;
                        ph_load  = 1'b1;
                        step_out = 1'b1;
                    end
                end
            end
            ST_TURN: begin
                if (ph_zero) begin
                    state_d  = ST_LOW;
                    ph_load  = 1'b1;
                    step_out = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequencer registers: bus pins, bit count, results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RST;
            bit_q   <= '0;
            wr_q    <= 1'b0;
            own_q   <= 1'b0;
            sck_q   <= 1'b1;
            oe_q    <= 1'b0;
            done_q  <= 1'b0;
            rd_q    <= '0;
            sdone_q <= 1'b0;
            sok_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= 1'b0;
            if (launch) begin
                bit_q <= '0;
                wr_q  <= launch_word[15];
                own_q <= (state_q == ST_PWAIT);
                sck_q <= 1'b0;
                oe_q  <= 1'b1;
            end
            if (step_out) sck_q <= 1'b0;
            if (rise) begin
                sck_q <= 1'b1;
                bit_q <= bit_q + 1'b1;
            end
            if (enter_turn) oe_q <= 1'b0;
            if (finish) begin
                oe_q <= 1'b0;
                if (own_q) begin
                    sdone_q <= 1'b1;
                    sok_q   <= (rx_byte[7:5] == 3'b000);
                end else begin
                    done_q <= 1'b1;
                    if (!wr_q) rd_q <= rx_byte;
                end
            end
        end
    end

    assign ready     = (state_q == ST_IDLE) && gap_zero;
    assign done      = done_q;
    assign rd_data   = rd_q;
    assign sync_done = sdone_q;
    assign sync_ok   = sok_q;
    assign sck       = sck_q;
    assign sdio_oe   = oe_q;

    AST_SDO_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(sdio_out)); // R3
    AST_TURN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TURN) |-> (!sdio_oe && sck)); // R4
    AST_GAP_BEFORE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck) |-> $past(gap_zero)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_READY_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (sck && !sdio_oe)); // R1

endmodule

// File: tb/test_sio_host_seq.sv
// Self-checking bench: a slave model on the bus, an edge-timing monitor,
// and directed plus seeded-random commands.
module test_sio_host_seq;
    localparam int HALF  = 3;
    localparam int TURN  = 40;
    localparam int WGAP  = 30;
    localparam int RGAP  = 12;
    localparam int PWUP  = 200;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_reset = 1'b0;
    logic [6:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic ready, done, sync_done, sync_ok, sck, sdio_out, sdio_oe;
    logic [7:0] rd_data;
    logic sdio_in = 1'b0;

    int n_chk = 0, n_bad = 0;
    int cyc = 0, wd = 0;
    logic [7:0] mem [128];
    logic [7:0] expm [128];

    sio_host_seq #(.HALF_CYC(HALF), .TURN_CYC(TURN), .WR_GAP_CYC(WGAP),
        .RD_GAP_CYC(RGAP), .PWRUP_CYC(PWUP), .PWRUP_EN(1'b1)) i_sio_host_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_reset(req_reset), .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .done(done), .rd_data(rd_data), .sync_done(sync_done),
        .sync_ok(sync_ok), .sck(sck), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
        .sdio_in(sdio_in));

    always #2 clk = ~clk; // 250 MHz

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] init_val(input int a);
        return 8'((a * 37 + 5) & 8'hFF);
    endfunction

    // Slave model: shifts in the command on rising sck, returns data on falling sck.
    logic [15:0] s_cmd;
    int  s_cnt = 0;
    logic s_rd = 1'b0;
    logic [7:0] s_tx;
    logic l_wr; logic [6:0] l_addr; logic [7:0] l_data;
    int  n_frames = 0;
    always @(posedge sck) begin
        if (rst_n) begin
            s_cmd = {s_cmd[14:0], sdio_out};
            s_cnt++;
            if (s_cnt == 8 && !s_cmd[7]) begin
                s_tx = mem[s_cmd[6:0]];
                s_rd = 1'b1;
            end
            if (s_cnt == 16) begin
                l_wr = s_cmd[15]; l_addr = s_cmd[14:8]; l_data = s_cmd[7:0];
                if (l_wr) mem[l_addr] = l_data;
                s_cnt = 0; s_rd = 1'b0; n_frames++;
            end
        end
    end
    always @(negedge sck) begin
        if (rst_n && s_rd && s_cnt >= 8) begin
            check(!sdio_oe, "R4 host released while slave drives", int'(sdio_oe), 0);
            sdio_in = s_tx[7];
            s_tx = {s_tx[6:0], 1'b0};
        end
    end

    // Edge-timing monitor, sampled mid-cycle.
    logic m_sck = 1'b1, m_sdo = 1'b0, m_wr = 1'b0, last_wr = 1'b0, have_prev = 1'b0;
    int m_bits = 0, t_rise = 0, t_fall = 0, n_done = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; m_sck = 1'b1; m_bits = 0; have_prev = 1'b0; m_sdo = sdio_out;
        end else begin
            cyc++;
            if (done) n_done++;
            if (m_sck && !sck) begin
                if (m_bits == 0) begin
                    if (!have_prev)
                        check(cyc >= PWUP, "R1 power-up wait", cyc, PWUP);
                    else if (last_wr)
                        check(cyc - t_rise >= WGAP, "R6 gap after write", cyc - t_rise, WGAP);
                    else
                        check(cyc - t_rise >= RGAP, "R7 gap after read", cyc - t_rise, RGAP);
                end else if (m_bits == 8 && !m_wr) begin
                    check(cyc - t_rise >= TURN, "R4 turnaround", cyc - t_rise, TURN);
                end else begin
                    check(cyc - t_rise >= HALF, "R2 high phase", cyc - t_rise, HALF);
                end
                t_fall = cyc;
            end else if (!m_sck && sck) begin
                check(cyc - t_fall == HALF, "R2 low phase", cyc - t_fall, HALF);
                m_bits++;
                if (m_bits == 1) m_wr = sdio_out;
                t_rise = cyc;
                if (m_bits == 16) begin
                    m_bits = 0; last_wr = m_wr; have_prev = 1'b1;
                end
            end else if (sdio_oe && sdio_out != m_sdo) begin
                check(1'b0, "R3 data moved outside a falling edge", int'(sdio_out), int'(m_sdo));
            end
            m_sck = sck; m_sdo = sdio_out;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            check(1'b0, "watchdog expired", wd, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic run_cmd(input bit wr, input bit rstc, input logic [6:0] a, input logic [7:0] d);
        logic [6:0] ea; logic [7:0] ed; bit ew; int to;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_reset = rstc; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_reset = 1'b0;
        req_write = ~wr; req_addr = ~a; req_wdata = ~d;
        check(!ready, "R8 ready low while busy", int'(ready), 0);
        to = 0;
        while (!done && to < 5000) begin @(negedge clk); to++; end
        check(done, "R8 done pulse", int'(done), 1);
        ew = rstc ? 1'b1 : wr; ea = rstc ? 7'h00 : a; ed = rstc ? 8'h80 : d;
        check(l_wr == ew && l_addr == ea, rstc ? "R9 soft reset frame" : "R3 frame header",
              int'({l_wr, l_addr}), int'({ew, ea}));
        if (ew) begin
            check(l_data == ed, rstc ? "R9 soft reset data" : "R3 write data", l_data, ed);
            expm[ea] = ed;
        end else begin
            check(rd_data == expm[ea], "R5 read data", rd_data, expm[ea]);
        end
        @(negedge clk);
        check(!done, "R8 done one cycle", int'(done), 0);
    endtask

    task automatic power_up(input logic [7:0] status, input bit exp_ok);
        int to;
        mem[1] = status; expm[1] = status;
        rst_n = 1'b0; s_cnt = 0; s_rd = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(sck && !ready && !sdio_oe, "R1 reset state", int'({sck, ready, sdio_oe}), 4);
        n_done = 0; n_frames = 0;
        to = 0;
        while (!sync_done && to < 2000) begin @(negedge clk); to++; end
        check(sync_done, "R10 sync done", int'(sync_done), 1);
        check(sync_ok == exp_ok, "R10 sync result", int'(sync_ok), int'(exp_ok));
        check(!l_wr && l_addr == 7'h01 && n_frames == 1, "R10 sync frame", int'(l_addr), 1);
        check(n_done == 0, "R10 no done for sync", n_done, 0);
    endtask

    initial begin
        int seed;
        seed = int'($urandom(32'h5EED));
        for (int i = 0; i < 128; i++) begin mem[i] = init_val(i); expm[i] = init_val(i); end
        power_up(8'hE3, 1'b0);
        power_up(8'h1B, 1'b1);
        // Directed corner cases
        run_cmd(1'b0, 1'b1, 7'h55, 8'h12);   // R9: fields ignored
        run_cmd(1'b0, 1'b0, 7'h00, 8'h00);   // read back soft reset value
        run_cmd(1'b1, 1'b0, 7'h7F, 8'hFF);   // write then read, R6
        run_cmd(1'b0, 1'b0, 7'h7F, 8'h00);
        run_cmd(1'b0, 1'b0, 7'h10, 8'h00);   // read then read, R7
        run_cmd(1'b1, 1'b0, 7'h10, 8'h01);   // read then write
        run_cmd(1'b0, 1'b0, 7'h10, 8'h00);
        // Seeded random mix
        for (int k = 0; k < 40; k++) begin
            run_cmd(1'($urandom), 1'b0, 7'($urandom), 8'($urandom));
        end
        repeat (50) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule